// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It latches incoming request lines into a pending register, holds a mask register and an in-service register, and continuously decides whether any request should be presented to the processor. Each line has its own trigger-mode bit: a level line's pending bit simply tracks its input, while an edge line records a rising transition and keeps it until the request is acknowledged.

Priority is relative to a programmable base. The line equal to the base is the most urgent, base+1 is next, and so on, wrapping modulo the line count. The resolver finds the most urgent unmasked pending line and the most urgent in-service line. It raises its request output only when the first strictly outranks the second, so a request never interrupts a handler of equal or higher urgency. Acknowledge, end-of-interrupt commands and a direct base load update the in-service set and the base. The line count must be a power of two.

Top module: `irq_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending, history, mask and in-service registers and the base become zero, so `irq_valid` is 0 after reset.
- R2: A line whose `trig_level` bit is 1 has its pending bit equal, after each clock edge, to the `req_in` bit sampled at that edge.
- R3: A line whose `trig_level` bit is 0 sets its pending bit when `req_in` is high at an edge and was low at the previous edge. A low input never clears that pending bit.
- R4: The candidate set is pending AND NOT mask. Priority position p (0 = most urgent) maps to line (p + base) mod 8. `irq_line` names the candidate line with the smallest position. `mask_wr` loads `mask_data` into the mask register, where bit i masks line i.
- R5: `irq_valid` is 1 only when the candidate's position is strictly smaller than the position of the most urgent in-service line. An empty set counts as position 8.
- R6: When `special_mask` is 1, in-service bits of masked lines are left out of the comparison of R5.
- R7: `ack` while `irq_valid` is 1 and `auto_eoi` is 0 sets the in-service bit of `irq_line`. `ack` while `irq_valid` is 0 changes nothing.
- R8: `ack` while `irq_valid` is 1 and `auto_eoi` is 1 sets no in-service bit. If `rot_on_aeoi` is also 1, the base becomes (`irq_line` + 1) mod 8.
- R9: An accepted `ack` clears the acknowledged line's pending bit only for an edge line. A level line's pending bit keeps following its input.
- R10: `eoi_cmd` = 2'b01 (non-specific) clears the in-service bit with the smallest position. With `eoi_rotate` = 1 it also sets the base to that line + 1 mod 8. It does nothing when nothing is in service.
- R11: `eoi_cmd` = 2'b10 (specific) clears the in-service bit of `eoi_line`. With `eoi_rotate` = 1 it sets the base to `eoi_line` + 1 mod 8. Codes 2'b00 and 2'b11 do nothing.
- R12: `rot_wr` loads `rot_data` into the base. When several base updates coincide, `rot_wr` wins over an end-of-interrupt rotation, which wins over an auto-EOI rotation. The base is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 8 | Request lines, already synchronous to clk |
| trig_level | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | 8 | New mask value |
| special_mask | input | 1 | Exclude masked lines from the in-service comparison |
| auto_eoi | input | 1 | Acknowledge without recording in-service |
| rot_on_aeoi | input | 1 | Rotate the base on an auto-EOI acknowledge |
| ack | input | 1 | Processor acknowledge strobe |
| eoi_cmd | input | 2 | End-of-interrupt command: 01 non-specific, 10 specific |
| eoi_rotate | input | 1 | Rotate the base along with the end-of-interrupt |
| eoi_line | input | 3 | Target line of a specific end-of-interrupt |
| rot_wr | input | 1 | Load strobe for the priority base |
| rot_data | input | 3 | New priority base |
| irq_valid | output | 1 | A request outranks everything in service |
| irq_line | output | 3 | Winning line number |
| pend_q | output | 8 | Pending register |
| svc_q | output | 8 | In-service register |
| prio_base | output | 3 | Current priority base |

## Verification
The hardest state to reach from the ports has a non-zero base, several lines in service with mixed trigger modes, and masked in-service lines, so that special-mask mode changes the result. It also needs an end-of-interrupt or base load to land in the same cycle as an acknowledge. Directed sequences build the first such cases step by step with hand-computed values. A seeded random phase then keeps acknowledge and end-of-interrupt traffic dense while rarely re-drawing trigger modes and mode bits, so in-service sets build up across many rotations. The random phase is compared each cycle with a bench model written from the requirements.

// File: rtl/irq_pkg.sv
// Package: shared encodings for the interrupt resolver.
// Assumes nothing beyond being compiled before the modules that import it.
package irq_pkg;
    typedef enum logic [1:0] {
        EOI_NONE    = 2'b00,
        EOI_NONSPEC = 2'b01,
        EOI_SPEC    = 2'b10,
        EOI_RSVD    = 2'b11
    } eoi_kind_e;
endpackage

// File: rtl/irq_prio_scan.sv
// Rotating priority scan: returns the smallest position p for which
// set_vec[(p + base) mod N] is 1, and that line; position N when empty.
// Assumes N is a power of two and base is already reduced modulo N.
module irq_prio_scan #(
    parameter int N  = 8,
    parameter int W  = $clog2(N),
    parameter int PW = W + 1
) (
    input  logic [N-1:0] set_vec,
    input  logic [W-1:0] base,
    output logic [PW-1:0] prio,
    output logic [W-1:0]  line
);
    // Scan from the least urgent position down so the most urgent hit wins.
    always_comb begin
        int idx;
        prio = PW'(N);
        line = '0;
        for (int p = N - 1; p >= 0; p--) begin
            idx = (p + int'(base)) % N;
            if (set_vec[idx]) begin
                prio = PW'(p);
                line = W'(idx);
            end
        end
    end
endmodule

// File: rtl/irq_req_bank.sv
// Request capture: one pending bit and one history bit per line.
// Level lines track the input; edge lines latch a rise and hold it
// until an acknowledge clear. Inputs are assumed synchronous to clk.
module irq_req_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] trig_level,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] pend_q
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic pend_b;
        logic hist_b;

        // Per-line pending and history update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_b <= 1'b0;
                hist_b <= 1'b0;
            end else begin
                hist_b <= req_in[i];
                if (trig_level[i])
                    pend_b <= req_in[i];
                else if (req_in[i] && !hist_b)
                    pend_b <= 1'b1;
                else if (ack_clr[i])
                    pend_b <= 1'b0;
            end
        end

        assign pend_q[i] = pend_b;
    end

    // R2: level lines mirror the sampled input.
    p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(trig_level)) ==
                          ($past(req_in) & $past(trig_level))));

    // R3 / R9: an edge line's pending bit falls only through an acknowledge.
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pend_q) & ~pend_q & ~$past(trig_level)
                           & ~$past(ack_clr)) == '0));
endmodule

// File: rtl/irq_svc_track.sv
// In-service register and priority base. Clear and set vectors come
// from the top; a set wins over a clear of the same bit.
module irq_svc_track #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic         base_ld,
    input  logic [W-1:0] base_nx,
    output logic [N-1:0] svc_q,
    output logic [W-1:0] base_q
);
    // In-service and base register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q  <= '0;
            base_q <= '0;
        end else begin
            svc_q <= (svc_q & ~clr_vec) | set_vec;
            if (base_ld)
                base_q <= base_nx;
        end
    end

    // R7: an in-service bit rises only where an acknowledge set it.
    p_svc_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((svc_q & ~$past(svc_q) & ~$past(set_vec)) == '0));

    // R12: the base holds when no update was requested.
    p_base_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(base_ld)) |-> $stable(base_q));
endmodule

// File: rtl/irq_resolver.sv
// Top of the rotating-priority interrupt resolver. Compares the most
// urgent unmasked request with the most urgent in-service line and
// handles acknowledge, end-of-interrupt and base loads.
// Assumes NLINES is a power of two and inputs are synchronous to clk.
module irq_resolver
    import irq_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int LW    = $clog2(NLINES),
    localparam int PW    = LW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_in,
    input  logic [NLINES-1:0] trig_level,
    input  logic              mask_wr,
    input  logic [NLINES-1:0] mask_data,
    input  logic              special_mask,
    input  logic              auto_eoi,
    input  logic              rot_on_aeoi,
    input  logic              ack,
    input  logic [1:0]        eoi_cmd,
    input  logic              eoi_rotate,
    input  logic [LW-1:0]     eoi_line,
    input  logic              rot_wr,
    input  logic [LW-1:0]     rot_data,
    output logic              irq_valid,
    output logic [LW-1:0]     irq_line,
    output logic [NLINES-1:0] pend_q,
    output logic [NLINES-1:0] svc_q,
    output logic [LW-1:0]     prio_base
);
    logic [NLINES-1:0] mask_q;
    logic [NLINES-1:0] cand_vec, cmp_vec;
    logic [NLINES-1:0] ack_set, ack_clr, eoi_clr;
    logic [PW-1:0]     cand_prio, cmp_prio, svc_prio;
    logic [LW-1:0]     cand_line, cmp_line, svc_line;
    logic              ack_fire, eoi_hit, base_ld;
    logic [LW-1:0]     eoi_tgt, base_nx;
    eoi_kind_e         eoi_kind;

    assign eoi_kind = eoi_kind_e'(eoi_cmd);

    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= mask_data;
    end

    irq_req_bank #(.N(NLINES)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (req_in),
        .trig_level (trig_level),
        .ack_clr    (ack_clr),
        .pend_q     (pend_q)
    );

    // Candidate and comparison sets.
    always_comb begin
        cand_vec = pend_q & ~mask_q;
        cmp_vec  = special_mask ? (svc_q & ~mask_q) : svc_q;
    end

    irq_prio_scan #(.N(NLINES), .W(LW), .PW(PW)) u_scan_cand (
        .set_vec (cand_vec), .base (prio_base), .prio (cand_prio), .line (cand_line)
    );
    irq_prio_scan #(.N(NLINES), .W(LW), .PW(PW)) u_scan_cmp (
        .set_vec (cmp_vec), .base (prio_base), .prio (cmp_prio), .line (cmp_line)
    );
    irq_prio_scan #(.N(NLINES), .W(LW), .PW(PW)) u_scan_svc (
        .set_vec (svc_q), .base (prio_base), .prio (svc_prio), .line (svc_line)
    );

    assign irq_valid = cand_prio < cmp_prio;
    assign irq_line  = cand_line;
    assign ack_fire  = ack && irq_valid;

    // Acknowledge effects on pending and in-service bits.
    always_comb begin
        ack_set = '0;
        ack_clr = '0;
        if (ack_fire) begin
            ack_clr = (NLINES'(1) << irq_line) & ~trig_level;
            if (!auto_eoi)
                ack_set = NLINES'(1) << irq_line;
        end
    end

    // End-of-interrupt target selection.
    always_comb begin
        eoi_hit = 1'b0;
        eoi_tgt = eoi_line;
        if (eoi_kind == EOI_SPEC) begin
            eoi_hit = 1'b1;
        end else if (eoi_kind == EOI_NONSPEC && svc_prio != PW'(NLINES)) begin
            eoi_hit = 1'b1;
            eoi_tgt = svc_line;
        end
        eoi_clr = eoi_hit ? (NLINES'(1) << eoi_tgt) : '0;
    end

    // Base update, lowest precedence first.
    always_comb begin
        base_ld = 1'b0;
        base_nx = prio_base;
        if (ack_fire && auto_eoi && rot_on_aeoi) begin
            base_ld = 1'b1;
            base_nx = irq_line + LW'(1);
        end
        if (eoi_hit && eoi_rotate) begin
            base_ld = 1'b1;
            base_nx = eoi_tgt + LW'(1);
        end
        if (rot_wr) begin
            base_ld = 1'b1;
            base_nx = rot_data;
        end
    end

    irq_svc_track #(.N(NLINES), .W(LW)) u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (ack_set),
        .clr_vec (eoi_clr),
        .base_ld (base_ld),
        .base_nx (base_nx),
        .svc_q   (svc_q),
        .base_q  (prio_base)
    );

    // R4: the winner is pending and unmasked.
    p_winner_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (pend_q[irq_line] && !mask_q[irq_line]));

    // R5: the winner is never a line already in service.
    p_winner_not_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !svc_q[irq_line]);

    // R8: an auto-EOI acknowledge leaves the in-service set without new bits.
    p_aeoi_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ack_fire && auto_eoi)) |-> ((svc_q & ~$past(svc_q)) == '0));

    // R10 / R11: an end-of-interrupt target is out of service afterwards.
    p_eoi_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((svc_q & $past(eoi_clr & ~ack_set)) == '0));

    // R1: reset leaves no request raised.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> !irq_valid);
endmodule

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0, trig_level = '0, mask_data = '0;
    logic       mask_wr = 0, special_mask = 0, auto_eoi = 0, rot_on_aeoi = 0;
    logic       ack = 0, eoi_rotate = 0, rot_wr = 0;
    logic [1:0] eoi_cmd = 2'b00;
    logic [2:0] eoi_line = '0, rot_data = '0;
    logic       irq_valid;
    logic [2:0] irq_line, prio_base;
    logic [7:0] pend_q, svc_q;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    irq_resolver u0 (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
        .mask_wr(mask_wr), .mask_data(mask_data), .special_mask(special_mask),
        .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .ack(ack),
        .eoi_cmd(eoi_cmd), .eoi_rotate(eoi_rotate), .eoi_line(eoi_line),
        .rot_wr(rot_wr), .rot_data(rot_data), .irq_valid(irq_valid),
        .irq_line(irq_line), .pend_q(pend_q), .svc_q(svc_q), .prio_base(prio_base)
    );

    // Bench model state, written from the requirements.
    logic [7:0] m_pend = '0, m_hist = '0, m_mask = '0, m_svc = '0;
    logic [2:0] m_base = '0;

    function automatic int f_prio(logic [7:0] s, logic [2:0] b);
        for (int p = 0; p < 8; p++)
            if (s[(p + int'(b)) % 8]) return p;
        return 8;
    endfunction

    function automatic logic [2:0] f_line(logic [7:0] s, logic [2:0] b);
        return 3'((f_prio(s, b) + int'(b)) % 8);
    endfunction

    function automatic logic f_valid();
        logic [7:0] cmpset;
        cmpset = special_mask ? (m_svc & ~m_mask) : m_svc;
        return f_prio(m_pend & ~m_mask, m_base) < f_prio(cmpset, m_base);
    endfunction

    // Model update on every edge.
    always @(posedge clk) begin
        logic [7:0] np, nh, ns, clr, st;
        logic [2:0] nb, wl;
        logic fire;
        if (!rst_n) begin
            m_pend = '0; m_hist = '0; m_mask = '0; m_svc = '0; m_base = '0;
        end else begin
            fire = ack && f_valid();
            wl = f_line(m_pend & ~m_mask, m_base);
            np = m_pend; nh = req_in; nb = m_base; clr = '0; st = '0;
            for (int i = 0; i < 8; i++) begin
                if (trig_level[i]) np[i] = req_in[i];
                else begin
                    if (fire && wl == 3'(i)) np[i] = 1'b0;
                    if (req_in[i] && !m_hist[i]) np[i] = 1'b1;
                end
            end
            if (fire && !auto_eoi) st[wl] = 1'b1;
            if (fire && auto_eoi && rot_on_aeoi) nb = wl + 3'd1;
            if (eoi_cmd == 2'b01 && m_svc != 0) begin
                clr[f_line(m_svc, m_base)] = 1'b1;
                if (eoi_rotate) nb = f_line(m_svc, m_base) + 3'd1;
            end else if (eoi_cmd == 2'b10) begin
                clr[eoi_line] = 1'b1;
                if (eoi_rotate) nb = eoi_line + 3'd1;
            end
            if (rot_wr) nb = rot_data;
            ns = (m_svc & ~clr) | st;
            if (mask_wr) m_mask = mask_data;
            m_pend = np; m_hist = nh; m_svc = ns; m_base = nb;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic cmp_model(input string tag);
        logic ev;
        ev = f_valid();
        chk_eq({tag, " valid"}, int'(irq_valid), int'(ev));
        if (ev) chk_eq({tag, " line"}, int'(irq_line), int'(f_line(m_pend & ~m_mask, m_base)));
        chk_eq({tag, " pend"}, int'(pend_q), int'(m_pend));
        chk_eq({tag, " svc"}, int'(svc_q), int'(m_svc));
        chk_eq({tag, " base"}, int'(prio_base), int'(m_base));
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk_eq("R1 valid", int'(irq_valid), 0);
        chk_eq("R1 pend", int'(pend_q), 0);
        chk_eq("R1 svc", int'(svc_q), 0);
        chk_eq("R1 base", int'(prio_base), 0);

        // R3: edge line 3 pulses, then stays pending with input low
        req_in = 8'h08; step(); req_in = 8'h00; step(); step();
        chk_eq("R3 pend held", int'(pend_q), 8'h08);
        chk_eq("R4 winner line3", int'(irq_line), 3);
        chk_eq("R4 valid", int'(irq_valid), 1);

        // R2: level line 5 follows its input
        trig_level = 8'h20; req_in = 8'h20; step();
        chk_eq("R2 pend high", int'(pend_q), 8'h28);
        req_in = 8'h00; step();
        chk_eq("R2 pend low", int'(pend_q), 8'h08);
        req_in = 8'h20; step();

        // R12 / R4: base 4 makes line 5 the winner
        rot_wr = 1; rot_data = 3'd4; step(); rot_wr = 0;
        chk_eq("R12 base", int'(prio_base), 4);
        chk_eq("R4 rotated winner", int'(irq_line), 5);

        // R4: masking line 5 exposes line 3
        mask_wr = 1; mask_data = 8'h20; step(); mask_wr = 0;
        chk_eq("R4 masked winner", int'(irq_line), 3);
        mask_wr = 1; mask_data = 8'h00; step(); mask_wr = 0;

        // R7 / R9: acknowledge level line 5
        ack = 1; step(); ack = 0;
        chk_eq("R7 svc set", int'(svc_q), 8'h20);
        chk_eq("R9 level stays pending", int'(pend_q), 8'h28);
        chk_eq("R5 equal rank blocked", int'(irq_valid), 0);

        // R6: special mask hides masked in-service line 5
        mask_wr = 1; mask_data = 8'h20; step(); mask_wr = 0;
        chk_eq("R6 without special mask", int'(irq_valid), 0);
        special_mask = 1; #1;
        chk_eq("R6 special mask valid", int'(irq_valid), 1);
        chk_eq("R6 special mask line", int'(irq_line), 3);
        special_mask = 0;
        mask_wr = 1; mask_data = 8'h00; step(); mask_wr = 0;

        // R7: acknowledge without a request changes nothing
        ack = 1; step(); ack = 0;
        chk_eq("R7 idle ack svc", int'(svc_q), 8'h20);
        chk_eq("R7 idle ack pend", int'(pend_q), 8'h28);

        // R10: non-specific EOI with rotate
        eoi_cmd = 2'b01; eoi_rotate = 1; step(); eoi_cmd = 2'b00; eoi_rotate = 0;
        chk_eq("R10 svc cleared", int'(svc_q), 0);
        chk_eq("R10 base", int'(prio_base), 6);
        chk_eq("R10 winner", int'(irq_line), 3);

        // R9 / R11: edge acknowledge, then specific EOIs
        ack = 1; step(); ack = 0;
        chk_eq("R9 edge cleared", int'(pend_q), 8'h20);
        chk_eq("R7 svc line3", int'(svc_q), 8'h08);
        eoi_cmd = 2'b10; eoi_line = 3'd3; step();
        chk_eq("R11 specific clear", int'(svc_q), 0);
        chk_eq("R11 base kept", int'(prio_base), 6);
        eoi_line = 3'd1; eoi_rotate = 1; step(); eoi_cmd = 2'b00; eoi_rotate = 0;
        chk_eq("R11 rotate base", int'(prio_base), 2);

        // R8: auto-EOI with rotation
        auto_eoi = 1; rot_on_aeoi = 1; ack = 1; step(); ack = 0;
        chk_eq("R8 no svc", int'(svc_q), 0);
        chk_eq("R8 base", int'(prio_base), 6);
        chk_eq("R8 level pending", int'(pend_q), 8'h20);
        cmp_model("R1 model sync");

        // Random phase: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 against the model
        for (int c = 0; c < 4000; c++) begin
            cmp_model("R4/R5 random");
            req_in ^= 8'($urandom & $urandom);
            ack = ($urandom % 4) == 0;
            eoi_cmd = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
            eoi_line = 3'($urandom);
            eoi_rotate = 1'($urandom);
            rot_wr = ($urandom % 32) == 0;
            rot_data = 3'($urandom);
            mask_wr = ($urandom % 16) == 0;
            mask_data = 8'($urandom & $urandom);
            if (c % 256 == 0) begin
                trig_level = 8'($urandom);
                auto_eoi = ($urandom % 3) == 0;
                rot_on_aeoi = 1'($urandom);
                special_mask = 1'($urandom);
            end
            step();
        end
        finish_run();
    end
endmodule